// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Comparator Bank

This block watches a 32-bit processor's instruction fetch and data traffic for debug events. It has a bank of instruction-breakpoint slots, each holding an arm bit and an address. It also has a bank of data-watchpoint slots, each holding a two-bit access kind and a byte address. Every fetch address is compared with the armed breakpoint slots. Every data request (word address, byte enables, write strobe) is compared with the watchpoint slots whose kind accepts that direction of access.

A hit raises a breakpoint or watchpoint exception request in the same cycle as the fetch or access that caused it. The data request is withheld from memory in that cycle, so a matched store never lands. A breakpoint takes priority over a watchpoint that hits in the same cycle, because the breakpoint is detected at fetch.

Slots are programmed through a one-cycle write port. The port can load a slot or clear it, and the new contents apply from the next clock edge.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every slot is disarmed, so no request is raised and `memGo` equals `memReq`.
- R2: A load to a breakpoint slot (`cfgBank`=0, `cfgClr`=0) arms it with `cfgAddr` from the next cycle on. `bkptReq` is then high in any cycle where `fetchValid` is high and `fetchPc` equals that address exactly.
- R3: A watchpoint load stores `cfgKind`. The encoding is 2'b00 disabled, 2'b01 reads only, 2'b10 writes only, 2'b11 both. `memWe`=1 marks a write and `memWe`=0 a read. A slot matches only an access of a direction its kind accepts.
- R4: A watchpoint slot of kind 2'b00 never matches, whatever address it holds.
- R5: A watchpoint watches one byte. It matches when `memAddr[31:2]` equals its address bits [31:2] and the byte-enable bit `memBe[slotAddr[1:0]]` is set. `memAddr[1:0]` is ignored.
- R6: `memGo` is `memReq` with any hit taken out. When a request is raised for the current access, the access is not passed on and a matched store is never performed.
- R7: When a breakpoint and a watchpoint hit in the same cycle, only `bkptReq` is raised and `wchpReq` stays low.
- R8: A clear (`cfgClr`=1) disarms the addressed slot from the next cycle on. Clearing a slot that is already empty changes no other slot.
- R9: `bkptReq` is raised only while `fetchValid` is high. `wchpReq` is raised only while `memReq` is high.
- R10: Each slot compares independently. A hit in any one slot of a bank raises that bank's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Slot write strobe |
| cfgClr | input | 1 | 1 clears the addressed slot, 0 loads it |
| cfgBank | input | 1 | 0 selects the breakpoint bank, 1 the watchpoint bank |
| cfgIdx | input | IDX_W | Slot index within the bank |
| cfgKind | input | 2 | Watchpoint access kind to load |
| cfgAddr | input | ADDR_W | Address to load |
| fetchValid | input | 1 | Fetch address is valid |
| fetchPc | input | ADDR_W | Current instruction address |
| memReq | input | 1 | Data access request |
| memWe | input | 1 | 1 for a write, 0 for a read |
| memAddr | input | ADDR_W | Data access address (word aligned, low bits ignored) |
| memBe | input | 4 | Byte enables of the access |
| bkptReq | output | 1 | Breakpoint exception request |
| wchpReq | output | 1 | Watchpoint exception request |
| memGo | output | 1 | Data access may proceed |

## Verification
The bench builds the block with two breakpoint slots and two watchpoint slots. With so few slots, the sweep can cover every watchpoint kind, both directions of access, all sixteen byte-enable patterns and all four watched byte lanes. The expected result of each combination is computed from the kind and lane arithmetic. A second slot in each bank allows the bench to check that each slot is independent and that a clear leaves the other slot alone. It also exercises same-cycle breakpoint priority and the gating by `fetchValid` and `memReq`.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  typedef enum logic [1:0] {
    WP_OFF = 2'b00,
    WP_RD  = 2'b01,
    WP_WR  = 2'b10,
    WP_RW  = 2'b11
  } wpKind_e;

  // Bank/operation strobes from control to datapath.
  typedef struct packed {
    logic bpLoad;
    logic bpClear;
    logic wpLoad;
    logic wpClear;
  } slotStrobe_t;

endpackage

// File: rtl/dbg_match_ctrl.sv
module dbg_match_ctrl
  import dbg_match_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgClr,
  input  logic               cfgBank,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               fetchValid,
  input  logic               memReq,
  input  logic               bpHitAny,
  input  logic               wpHitAny,
  output slotStrobe_t        strobe,
  output logic [NUM_SEL-1:0] slotSel,
  output logic               bkptReq,
  output logic               wchpReq,
  output logic               memGo
);

  always_comb begin
    strobe.bpLoad  = cfgWe && !cfgBank && !cfgClr;
    strobe.bpClear = cfgWe && !cfgBank &&  cfgClr;
    strobe.wpLoad  = cfgWe &&  cfgBank && !cfgClr;
    strobe.wpClear = cfgWe &&  cfgBank &&  cfgClr;
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign slotSel[i] = (cfgIdx == IDX_W'(i));
  end

  logic bpLive, wpLive;
  assign bpLive  = fetchValid && bpHitAny;
  assign wpLive  = memReq && wpHitAny;
  assign bkptReq = bpLive;
  assign wchpReq = wpLive && !bpLive;
  assign memGo   = memReq && !bpLive && !wpLive;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(bkptReq && wchpReq)); // R7
  AST_WP_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    wchpReq |-> !memGo); // R6
  AST_BP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    bkptReq |-> fetchValid); // R9
  AST_WP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    wchpReq |-> memReq); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.bpLoad, strobe.bpClear, strobe.wpLoad, strobe.wpClear})); // R8

endmodule

// File: rtl/dbg_match_dpath.sv
module dbg_match_dpath
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 4,
  parameter int ADDR_W  = 32,
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotStrobe_t        strobe,
  input  logic [NUM_SEL-1:0] slotSel,
  input  logic [1:0]         cfgKind,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  fetchPc,
  input  logic               memWe,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [3:0]         memBe,
  output logic               bpHitAny,
  output logic               wpHitAny
);

  localparam int WORD_HI = ADDR_W - 1;

  logic [NUM_BP-1:0] bpHit;
  logic [NUM_WP-1:0] wpHit;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic              bpArm;
    logic [ADDR_W-1:0] bpAddr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bpArm  <= 1'b0;
        bpAddr <= '0;
      end else if (slotSel[i] && strobe.bpLoad) begin
        bpArm  <= 1'b1;
        bpAddr <= cfgAddr;
      end else if (slotSel[i] && strobe.bpClear) begin
        bpArm  <= 1'b0;
      end
    end

    assign bpHit[i] = bpArm && (fetchPc == bpAddr);

    AST_BP_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.bpClear && slotSel[i]) |=> !bpHit[i]); // R8
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    wpKind_e           wpKind;
    logic [ADDR_W-1:0] wpAddr;
    logic              dirOk;
    logic              wordOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wpKind <= WP_OFF;
        wpAddr <= '0;
      end else if (slotSel[i] && strobe.wpLoad) begin
        wpKind <= wpKind_e'(cfgKind);
        wpAddr <= cfgAddr;
      end else if (slotSel[i] && strobe.wpClear) begin
        wpKind <= WP_OFF;
      end
    end

    assign dirOk    = memWe ? wpKind[1] : wpKind[0];
    assign wordOk   = (memAddr[WORD_HI:2] == wpAddr[WORD_HI:2]);
    assign wpHit[i] = dirOk && wordOk && memBe[wpAddr[1:0]];

    AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (!rstN)
      (wpKind == WP_OFF) |-> !wpHit[i]); // R4
    AST_WP_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wpClear && slotSel[i]) |=> !wpHit[i]); // R8
  end

  assign bpHitAny = |bpHit;
  assign wpHitAny = |wpHit;

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 4,
  parameter int ADDR_W  = 32,
  localparam int NUM_SEL = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
  localparam int IDX_W   = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgClr,
  input  logic              cfgBank,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgKind,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [3:0]        memBe,
  output logic              bkptReq,
  output logic              wchpReq,
  output logic              memGo
);

  slotStrobe_t        strobe;
  logic [NUM_SEL-1:0] slotSel;
  logic               bpHitAny, wpHitAny;

  dbg_match_ctrl #(.NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgClr(cfgClr), .cfgBank(cfgBank), .cfgIdx(cfgIdx),
    .fetchValid(fetchValid), .memReq(memReq),
    .bpHitAny(bpHitAny), .wpHitAny(wpHitAny),
    .strobe(strobe), .slotSel(slotSel),
    .bkptReq(bkptReq), .wchpReq(wchpReq), .memGo(memGo)
  );

  dbg_match_dpath #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .ADDR_W(ADDR_W),
                    .NUM_SEL(NUM_SEL)) u_dpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .slotSel(slotSel),
    .cfgKind(cfgKind), .cfgAddr(cfgAddr),
    .fetchPc(fetchPc), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .bpHitAny(bpHitAny), .wpHitAny(wpHitAny)
  );

endmodule

// File: tb/tb_dbg_match_unit.sv
module tb_dbg_match_unit;

  localparam int NB = 2;
  localparam int NW = 2;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0, cfgClr = 1'b0, cfgBank = 1'b0;
  logic [0:0]    cfgIdx = '0;
  logic [1:0]    cfgKind = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic          fetchValid = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic          memReq = 1'b0, memWe = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic [3:0]    memBe = '0;
  logic          bkptReq, wchpReq, memGo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_match_unit #(.NUM_BP(NB), .NUM_WP(NW), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgClr(cfgClr), .cfgBank(cfgBank), .cfgIdx(cfgIdx),
    .cfgKind(cfgKind), .cfgAddr(cfgAddr),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .bkptReq(bkptReq), .wchpReq(wchpReq), .memGo(memGo)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One write-port cycle; the result is visible after the following edge.
  task automatic cfg(input logic bank, input logic clr, input int idx,
                     input logic [1:0] kind, input logic [AW-1:0] addr);
    @(negedge clk);
    cfgWe = 1'b1; cfgClr = clr; cfgBank = bank; cfgIdx = 1'(idx);
    cfgKind = kind; cfgAddr = addr;
    @(negedge clk);
    cfgWe = 1'b0; cfgClr = 1'b0;
  endtask

  task automatic drive(input logic fv, input logic [AW-1:0] pc, input logic mr,
                       input logic we, input logic [AW-1:0] ma, input logic [3:0] be);
    fetchValid = fv; fetchPc = pc; memReq = mr; memWe = we; memAddr = ma; memBe = be;
    #2;
  endtask

  localparam logic [AW-1:0] BP_A = 32'h0000_1040;
  localparam logic [AW-1:0] BP_B = 32'h8000_2200;
  localparam logic [AW-1:0] WBASE = 32'h4000_0100;

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    drive(1'b1, 32'h0, 1'b1, 1'b1, 32'h0, 4'hF);
    check("R1 bkpt after reset", bkptReq, 1'b0);
    check("R1 wchp after reset", wchpReq, 1'b0);
    check("R1 memGo after reset", memGo, 1'b1);
    drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0);

    // R2/R10: two breakpoint slots
    cfg(1'b0, 1'b0, 0, 2'b00, BP_A);
    cfg(1'b0, 1'b0, 1, 2'b00, BP_B);
    drive(1'b1, BP_A, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R2 slot0 hit", bkptReq, 1'b1);
    drive(1'b1, BP_B, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R10 slot1 hit", bkptReq, 1'b1);
    drive(1'b1, BP_A + 4, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R2 near miss", bkptReq, 1'b0);
    drive(1'b1, BP_A ^ 32'h8000_0000, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R2 msb differs", bkptReq, 1'b0);
    drive(1'b0, BP_A, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R9 fetch not valid", bkptReq, 1'b0);

    // R3/R4/R5/R6: exhaustive kind x direction x lane x byte enables
    cfg(1'b1, 1'b1, 1, 2'b00, 32'h0);
    for (int kind = 0; kind < 4; kind++) begin
      for (int lane = 0; lane < 4; lane++) begin
        cfg(1'b1, 1'b0, 0, 2'(kind), WBASE + AW'(lane));
        for (int we = 0; we < 2; we++) begin
          for (int be = 0; be < 16; be++) begin
            logic dirOk, exp;
            dirOk = (we == 1) ? ((kind & 2) != 0) : ((kind & 1) != 0);
            exp = dirOk && (((be >> lane) & 1) == 1);
            drive(1'b0, 32'h0, 1'b1, 1'(we), WBASE + AW'((be + lane) & 3), 4'(be));
            if (kind == 0) check("R4 disabled slot", wchpReq, 1'b0);
            else check("R3 R5 kind/lane match", wchpReq, exp);
            check("R6 memGo gating", memGo, !exp);
          end
        end
        drive(1'b0, 32'h0, 1'b1, 1'b1, WBASE + 4, 4'hF);
        check("R5 other word", wchpReq, 1'b0);
        drive(1'b0, 32'h0, 1'b0, 1'b1, WBASE, 4'hF);
        check("R9 no request", wchpReq, 1'b0);
        check("R9 memGo idle", memGo, 1'b0);
      end
    end

    // R10: second watchpoint slot independent
    cfg(1'b1, 1'b0, 0, 2'b11, WBASE);
    cfg(1'b1, 1'b0, 1, 2'b10, WBASE + 32'h13);
    drive(1'b0, 32'h0, 1'b1, 1'b1, WBASE + 32'h10, 4'b1000);
    check("R10 wp slot1 write", wchpReq, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 1'b0, WBASE + 32'h10, 4'b1000);
    check("R10 wp slot1 read ignored", wchpReq, 1'b0);

    // R7: same-cycle priority
    drive(1'b1, BP_A, 1'b1, 1'b1, WBASE, 4'h1);
    check("R7 bkpt wins", bkptReq, 1'b1);
    check("R7 wchp held low", wchpReq, 1'b0);
    check("R6 store blocked", memGo, 1'b0);

    // R8: clears
    cfg(1'b0, 1'b1, 0, 2'b00, 32'h0);
    drive(1'b1, BP_A, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R8 cleared bp slot0", bkptReq, 1'b0);
    cfg(1'b0, 1'b1, 0, 2'b00, 32'h0);
    drive(1'b1, BP_B, 1'b0, 1'b0, 32'h0, 4'h0);
    check("R8 empty clear keeps slot1", bkptReq, 1'b1);
    cfg(1'b1, 1'b1, 0, 2'b00, 32'h0);
    drive(1'b0, 32'h0, 1'b1, 1'b0, WBASE, 4'hF);
    check("R8 cleared wp slot0", wchpReq, 1'b0);
    check("R8 memGo after clear", memGo, 1'b1);
    drive(1'b0, 32'h0, 1'b1, 1'b1, WBASE + 32'h10, 4'b1000);
    check("R8 wp slot1 kept", wchpReq, 1'b1);

    drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule